// File: doc/BRIEF.md
# STN Panel Line and Frame Timing Generator

This block produces the raster timing for a passive-matrix (STN) LCD panel. It divides the system clock into a shift clock. Shift clocks are grouped into lines and lines into frames. Each line carries a line-sync pulse and, on active rows, a load strobe and a data-enable window. The first line of each frame is marked by a frame sync. Pixel fetch and data formatting sit outside the block. They use `data_en` to know when a shift clock carries valid segment data.

Software programs the block through a small write-only register port. The programmable values are the line total, the frame total, the horizontal and vertical front delays, the active width and height, the shift-clock prescale, and a data-phase bit. The back porches are whatever the totals leave after the front delays and the active region. When a setting would leave less than the minimum porch, the block stretches the total to keep the porch legal and raises an error flag. A clear enable bit stops everything at once. All other settings are double-buffered and switch over at a frame boundary.

Top module: `stn_lcd_timing`

## Requirements
- R1: While the run bit (CTRL bit 0) is clear, and after reset, every output is low and all counters are held at zero. The reset value of every register is zero.
- R2: The shift clock period is D = 4 << PS system clocks, where PS is CTRL bits 2:1. Within each period the shift clock is low for the first D/2 clocks and high for the last D/2.
- R3: A line lasts HL+1 shift clocks. `line_sync` is high for exactly the first shift-clock period of every line.
- R4: A frame lasts VL+1 lines. `frame_sync` is high throughout line 0 of every frame.
- R5: A line is active when its index lies in [VDLY, VDLY+ACTH). On active lines only, `load_strobe` is high for the single shift-clock period whose index in the line equals HDLY, where index 0 is the line-sync slot.
- R6: On active lines, `data_en` is high for ACTW consecutive shift clocks. The window starts at slot HDLY when the phase bit (CTRL bit 3) is 0, and at slot HDLY+1 when it is 1. It is low at all other times.
- R7: HL = max(HTOT, HDLY+ACTW+phase+1), so the horizontal back porch after the data window is at least two shift clocks.
- R8: VL = max(VTOT, VDLY+ACTH), so at least one inactive line ends every frame. `cfg_err` is high while running whenever R7 or R8 had to stretch a total.
- R9: A write to any register other than CTRL bit 0 takes effect only at the next frame boundary while running. While stopped, writes take effect immediately. The run bit always acts on the next clock.
- R10: Register map on `reg_addr`: 0 CTRL, 1 HTOT (16 bits), 2 VTOT (10 bits), 3 HDLY (7 bits), 4 VDLY (7 bits), 5 ACTW (16 bits), 6 ACTH (10 bits). The low bits of `reg_wdata` are used. Address 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| shift_clk | output | 1 | Panel shift clock |
| line_sync | output | 1 | One shift clock wide pulse at each line start |
| frame_sync | output | 1 | High during the first line of each frame |
| load_strobe | output | 1 | Line load strobe on active lines |
| data_en | output | 1 | Valid segment data window |
| cfg_err | output | 1 | Settings were stretched to keep minimum porches |

## Verification
The assertions check, on every cycle, the following properties: outputs stay silent while stopped, the shift clock is high on each slot boundary, line sync and load strobe each last one slot, the data window respects the two-slot back porch, the last line of a frame is inactive, and the shadow settings stay fixed between frame boundaries. The exact line and frame lengths, the position of the window for each phase and prescale, the clamp arithmetic and its error flag, and the deferred switch-over of a mid-frame write can only be shown by the bench. It does this with its cycle reference model and measured line periods.

// File: rtl/stn_tim_pkg.sv
package stn_tim_pkg;
  localparam int HT_W   = 16;
  localparam int VT_W   = 10;
  localparam int DLY_W  = 7;
  localparam int PS_W   = 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int HC_W   = HT_W + 2;
  localparam int VC_W   = VT_W + 2;
  localparam int PC_W   = 2 + (1 << PS_W) - 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_HTOT = 3'd1,
    A_VTOT = 3'd2,
    A_HDLY = 3'd3,
    A_VDLY = 3'd4,
    A_ACTW = 3'd5,
    A_ACTH = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [PS_W-1:0]  psel;
    logic             phase;
    logic [HT_W-1:0]  htot;
    logic [VT_W-1:0]  vtot;
    logic [DLY_W-1:0] hdly;
    logic [DLY_W-1:0] vdly;
    logic [HT_W-1:0]  actw;
    logic [VT_W-1:0]  acth;
  } cfg_t;

  function automatic logic [PC_W:0] clk_div(input logic [PS_W-1:0] sel);
    return (PC_W+1)'(4) << sel;
  endfunction

  function automatic logic [HC_W-1:0] h_need(input cfg_t c);
    return HC_W'(c.hdly) + HC_W'(c.actw) + HC_W'(c.phase) + HC_W'(1);
  endfunction

  function automatic logic [VC_W-1:0] v_need(input cfg_t c);
    return VC_W'(c.vdly) + VC_W'(c.acth);
  endfunction

  function automatic logic [HC_W-1:0] h_last_of(input cfg_t c);
    return (HC_W'(c.htot) >= h_need(c)) ? HC_W'(c.htot) : h_need(c);
  endfunction

  function automatic logic [VC_W-1:0] v_last_of(input cfg_t c);
    return (VC_W'(c.vtot) >= v_need(c)) ? VC_W'(c.vtot) : v_need(c);
  endfunction

  function automatic logic clamped(input cfg_t c);
    return (HC_W'(c.htot) < h_need(c)) || (VC_W'(c.vtot) < v_need(c));
  endfunction
endpackage

// File: rtl/stn_cfg_regs.sv
module stn_cfg_regs
  import stn_tim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_end,
  output logic              run,
  output cfg_t              active
);
  cfg_t stg, stg_d;
  logic run_d;
  logic reload;

  always_comb begin
    stg_d = stg;
    run_d = run;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run_d       = wr_data[0];
          stg_d.psel  = wr_data[PS_W:1];
          stg_d.phase = wr_data[PS_W+1];
        end
        A_HTOT:  stg_d.htot = wr_data[HT_W-1:0];
        A_VTOT:  stg_d.vtot = wr_data[VT_W-1:0];
        A_HDLY:  stg_d.hdly = wr_data[DLY_W-1:0];
        A_VDLY:  stg_d.vdly = wr_data[DLY_W-1:0];
        A_ACTW:  stg_d.actw = wr_data[HT_W-1:0];
        A_ACTH:  stg_d.acth = wr_data[VT_W-1:0];
        default: ;
      endcase
    end
  end

  assign reload = !run || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg    <= '0;
      run    <= 1'b0;
      active <= '0;
    end else begin
      stg <= stg_d;
      run <= run_d;
      if (reload) active <= stg_d;
    end
  end
endmodule

// File: rtl/stn_prescaler.sv
module stn_prescaler
  import stn_tim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] sel,
  output logic            shift_clk,
  output logic            slot_end
);
  logic [PC_W-1:0] cnt;
  logic [PC_W:0]   div;

  assign div       = clk_div(sel);
  assign slot_end  = run && ({1'b0, cnt} == div - (PC_W+1)'(1));
  assign shift_clk = run && ({1'b0, cnt} >= (div >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || slot_end) cnt <= '0;
    else                       cnt <= cnt + PC_W'(1);
  end
endmodule

// File: rtl/stn_raster_counter.sv
module stn_raster_counter
  import stn_tim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            slot_end,
  input  logic [HC_W-1:0] h_last,
  input  logic [VC_W-1:0] v_last,
  output logic [HC_W-1:0] hcnt,
  output logic [VC_W-1:0] vcnt,
  output logic            line_last,
  output logic            frame_end
);
  assign line_last = (hcnt == h_last);
  assign frame_end = slot_end && line_last && (vcnt == v_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (slot_end) begin
      if (line_last) begin
        hcnt <= '0;
        vcnt <= (vcnt == v_last) ? '0 : vcnt + VC_W'(1);
      end else begin
        hcnt <= hcnt + HC_W'(1);
      end
    end
  end
endmodule

// File: rtl/stn_lcd_timing.sv
module stn_lcd_timing
  import stn_tim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              shift_clk,
  output logic              line_sync,
  output logic              frame_sync,
  output logic              load_strobe,
  output logic              data_en,
  output logic              cfg_err
);
  cfg_t            active;
  logic            run;
  logic            slot_end;
  logic            frame_end;
  logic            line_last;
  logic [HC_W-1:0] hcnt, h_last;
  logic [VC_W-1:0] vcnt, v_last;
  logic [HC_W-1:0] win_lo, win_hi;
  logic [VC_W-1:0] row_lo, row_hi;
  logic            row_act;

  stn_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .frame_end(frame_end), .run(run), .active(active)
  );

  stn_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(active.psel),
    .shift_clk(shift_clk), .slot_end(slot_end)
  );

  assign h_last = h_last_of(active);
  assign v_last = v_last_of(active);

  stn_raster_counter u_rast (
    .clk(clk), .rst_n(rst_n), .run(run), .slot_end(slot_end),
    .h_last(h_last), .v_last(v_last), .hcnt(hcnt), .vcnt(vcnt),
    .line_last(line_last), .frame_end(frame_end)
  );

  assign row_lo  = VC_W'(active.vdly);
  assign row_hi  = row_lo + VC_W'(active.acth);
  assign win_lo  = HC_W'(active.hdly) + HC_W'(active.phase);
  assign win_hi  = win_lo + HC_W'(active.actw);
  assign row_act = (vcnt >= row_lo) && (vcnt < row_hi);

  assign line_sync   = run && (hcnt == '0);
  assign frame_sync  = run && (vcnt == '0);
  assign load_strobe = run && row_act && (hcnt == HC_W'(active.hdly));
  assign data_en     = run && row_act && (hcnt >= win_lo) && (hcnt < win_hi);
  assign cfg_err     = run && clamped(active);
endmodule

// File: rtl/stn_lcd_timing_chk.sv
module stn_lcd_timing_chk
  import stn_tim_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            slot_end,
  input logic            frame_end,
  input logic [HC_W-1:0] hcnt,
  input logic [VC_W-1:0] vcnt,
  input logic [HC_W-1:0] h_last,
  input logic [VC_W-1:0] v_last,
  input cfg_t            active,
  input logic            shift_clk,
  input logic            line_sync,
  input logic            frame_sync,
  input logic            load_strobe,
  input logic            data_en,
  input logic            cfg_err
);
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(shift_clk || line_sync || frame_sync || load_strobe || data_en || cfg_err)); // R1
  AST_SLOT_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> shift_clk); // R2
  AST_LSYNC_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && line_sync && run) |=> !line_sync); // R3
  AST_LOAD_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && load_strobe && run) |=> !load_strobe); // R5
  AST_H_BACK_PORCH: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> ((HC_W+1)'(hcnt) + (HC_W+1)'(2) <= (HC_W+1)'(h_last))); // R7
  AST_V_BACK_PORCH: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt == v_last) |-> !(load_strobe || data_en)); // R8
  AST_FSYNC_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> (vcnt == '0)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(frame_end)) |-> $stable(active)); // R9
endmodule

bind stn_lcd_timing stn_lcd_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .slot_end(slot_end),
  .frame_end(frame_end), .hcnt(hcnt), .vcnt(vcnt), .h_last(h_last),
  .v_last(v_last), .active(active), .shift_clk(shift_clk),
  .line_sync(line_sync), .frame_sync(frame_sync),
  .load_strobe(load_strobe), .data_en(data_en), .cfg_err(cfg_err)
);

// File: tb/stn_lcd_timing_test.sv
module stn_lcd_timing_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic shift_clk, line_sync, frame_sync, load_strobe, data_en, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stn_lcd_timing uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .shift_clk(shift_clk), .line_sync(line_sync),
    .frame_sync(frame_sync), .load_strobe(load_strobe), .data_en(data_en),
    .cfg_err(cfg_err)
  );

  // reference model state: staged (s_), current (c_), counters
  int m_run, s_ps, s_ph, s_ht, s_vt, s_hd, s_vd, s_aw, s_ah;
  int c_ps, c_ph, c_ht, c_vt, c_hd, c_vd, c_aw, c_ah;
  int n_run, n_ps, n_ph, n_ht, n_vt, n_hd, n_vd, n_aw, n_ah;
  int pc, h, v;
  bit fe;

  function automatic int m_div();  return 4 << c_ps; endfunction
  function automatic int m_hneed(); return c_hd + c_aw + c_ph + 1; endfunction
  function automatic int m_hl();   return (c_ht >= m_hneed()) ? c_ht : m_hneed(); endfunction
  function automatic int m_vl();   return (c_vt >= c_vd + c_ah) ? c_vt : c_vd + c_ah; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; pc = 0; h = 0; v = 0;
      s_ps = 0; s_ph = 0; s_ht = 0; s_vt = 0; s_hd = 0; s_vd = 0; s_aw = 0; s_ah = 0;
      c_ps = 0; c_ph = 0; c_ht = 0; c_vt = 0; c_hd = 0; c_vd = 0; c_aw = 0; c_ah = 0;
    end else begin
      n_run = m_run; n_ps = s_ps; n_ph = s_ph; n_ht = s_ht; n_vt = s_vt;
      n_hd = s_hd; n_vd = s_vd; n_aw = s_aw; n_ah = s_ah;
      if (reg_we) begin
        case (reg_addr)  // R10 map
          3'd0: begin n_run = reg_wdata[0]; n_ps = reg_wdata[2:1]; n_ph = reg_wdata[3]; end
          3'd1: n_ht = reg_wdata;
          3'd2: n_vt = reg_wdata[9:0];
          3'd3: n_hd = reg_wdata[6:0];
          3'd4: n_vd = reg_wdata[6:0];
          3'd5: n_aw = reg_wdata;
          3'd6: n_ah = reg_wdata[9:0];
          default: ;
        endcase
      end
      fe = m_run && pc == m_div() - 1 && h == m_hl() && v == m_vl();
      if (!m_run) begin pc = 0; h = 0; v = 0; end
      else if (pc == m_div() - 1) begin
        pc = 0;
        if (h == m_hl()) begin h = 0; v = (v == m_vl()) ? 0 : v + 1; end
        else h = h + 1;
      end else pc = pc + 1;
      if (!m_run || fe) begin
        c_ps = n_ps; c_ph = n_ph; c_ht = n_ht; c_vt = n_vt;
        c_hd = n_hd; c_vd = n_vd; c_aw = n_aw; c_ah = n_ah;
      end
      s_ps = n_ps; s_ph = n_ph; s_ht = n_ht; s_vt = n_vt;
      s_hd = n_hd; s_vd = n_vd; s_aw = n_aw; s_ah = n_ah;
      m_run = n_run;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit row;
      row = (v >= c_vd) && (v < c_vd + c_ah);
      if (!m_run) begin
        chk("R1", "quiet", shift_clk | line_sync | frame_sync | load_strobe | data_en | cfg_err, 1'b0);
      end else begin
        chk("R2", "shift_clk", shift_clk, pc >= m_div() / 2);
        chk("R3", "line_sync", line_sync, h == 0);
        chk("R4", "frame_sync", frame_sync, v == 0);
        chk("R5", "load_strobe", load_strobe, row && h == c_hd);
        chk("R6", "data_en", data_en, row && h >= c_hd + c_ph && h < c_hd + c_ph + c_aw);
        chk("R8", "cfg_err", cfg_err, (c_ht < m_hneed()) || (c_vt < c_vd + c_ah));
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic line_len(input string req, input int exp);
    int n = 0;
    @(negedge clk);
    while (line_sync) @(negedge clk);
    while (!line_sync) @(negedge clk);
    @(negedge clk); n = 1;
    while (line_sync) begin @(negedge clk); n++; end
    while (!line_sync) begin @(negedge clk); n++; end
    checks++;
    if (n != exp) begin
      errors++;
      $display("FAIL %s line length actual=%0d expected=%0d", req, n, exp);
    end
  endtask

  task automatic wait_frame();
    @(negedge clk);
    while (frame_sync) @(negedge clk);
    while (!frame_sync) @(negedge clk);
  endtask

  task automatic setup(input int ht, input int vt, input int hd, input int vd,
                       input int aw, input int ah, input int ctrl);
    wr(0, 0);
    wr(1, ht); wr(2, vt); wr(3, hd); wr(4, vd); wr(5, aw); wr(6, ah);
    wr(0, ctrl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);  // R1 reset state
    // scenario A: R3 R10 base timing, prescale /4
    setup(9, 5, 2, 1, 4, 3, 1);
    repeat (500) @(negedge clk);
    line_len("R3 R10", 10 * 4);
    // R9: mid-run write deferred to frame boundary
    wait_frame();
    wr(1, 15);
    line_len("R9 old total", 10 * 4);
    wait_frame();
    line_len("R9 new total", 16 * 4);
    wr(0, 0);
    repeat (20) @(negedge clk);  // R1 stopped
    // scenario B: R2 R6 prescale /8, phase 1
    setup(9, 5, 2, 1, 4, 3, 1 | (1 << 1) | (1 << 3));
    repeat (1000) @(negedge clk);
    line_len("R2", 10 * 8);
    // scenario C: R7 R8 clamping
    setup(3, 1, 2, 1, 4, 3, 1);
    repeat (600) @(negedge clk);
    line_len("R7", 8 * 4);
    chk("R8", "cfg_err clamp", cfg_err, 1'b1);
    // scenario D: R2 R5 prescale /32, zero delay
    setup(2, 2, 0, 0, 1, 1, 1 | (3 << 1));
    repeat (1000) @(negedge clk);
    line_len("R2 R5", 3 * 32);
    // address 7 is ignored (R10)
    wr(7, 16'hffff);
    repeat (300) @(negedge clk);
    wr(0, 0);
    repeat (20) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule